// File: doc/BRIEF.md
# ROM Signature Checker

This block confirms that a read-only memory still holds what was programmed into it. After a start request it steps through the whole address space, one address per clock. It folds every data word except the last into a 16-bit cyclic redundancy check. The last word of the memory holds the check value that was computed when the image was built. The block reads that word and compares it with the recomputed value, so no golden value has to come from outside the memory under test.

The memory is a plain synchronous read port: the block drives an address and the data for it comes back one clock later. The CRC update therefore runs one stage behind address generation. At the end of a run the block raises a one-cycle completion pulse, and a pass flag stays valid until the next start. The fault model is unidirectional stuck-at, where every faulty bit is stuck at 0 or every faulty bit is stuck at 1. Single-bit errors, double-bit errors, odd-count errors and short bursts all change the signature.

Top module: `rom_sig_chk`

## Requirements
- R1: While reset is held and after its release, done_o is 0, pass_o is 0 and rom_addr_o is 0 until a start is accepted.
- R2: A start accepted on a clock edge makes rom_addr_o present address 0 in the following cycle, then each next address once per cycle, up to the last address DEPTH-1 (DEPTH = 2^ADDR_W).
- R3: done_o goes high in the cycle that follows the (DEPTH+1)-th clock edge after the edge that accepted start_i, and stays high for exactly one cycle.
- R4: The signature is CRC-16 with polynomial 0x1021 and seed 0xFFFF, with no reflection and no final inversion. It covers words 0 to DEPTH-2 in address order, one whole word per step, most significant bit first.
- R5: At done_o, pass_o is 1 exactly when the computed signature equals the 16-bit word stored at address DEPTH-1. pass_o never rises outside the done_o cycle.
- R6: pass_o keeps its value from the end of a run until the next accepted start, and it is cleared on the edge that accepts that start.
- R7: A start_i pulse while a run is in progress is ignored: the address sequence and the done_o timing are unchanged.
- R8: Any single flipped bit anywhere in the memory, including in the stored signature, gives pass_o = 0.
- R9: Any two flipped bits, in the same word or in different words, give pass_o = 0.
- R10: Any odd number of flipped bits gives pass_o = 0.
- R11: A burst of up to 16 adjacent flipped bits gives pass_o = 0, including a burst that crosses a word boundary. Bits run from bit 15 down to bit 0 of one word, then into bit 15 of the next word.
- R12: When one data bit is stuck at 0 (or stuck at 1) across every word, pass_o reports whether the corrupted image still matches its own corrupted reference word under the R4 signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a check run; accepted only when idle |
| rom_addr_o | output | ADDR_W | Read address to the memory |
| rom_data_i | input | DATA_W | Read data, valid one cycle after its address |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Result of the last run; 1 means signature matched |

## Verification
Clean images are checked with four data patterns: all zero, an address ramp, alternating 0xAAAA/0x5555 and a pseudo-random fill. A passing result on each confirms the polynomial, the seed and the bit order. An image signed with seed 0 must fail, which proves that the seed is applied. Corrupted images receive single flips (one in data, one in the stored reference word), a double flip, a triple flip and a 12-bit burst across a word boundary, and each must be rejected. Stuck columns at 0 and at 1 are compared against a separately written signature model. The scenarios also cover a mid-run start pulse, which must not disturb the address sequence or the completion timing, and the holding and clearing of the pass flag between runs.

// File: rtl/rom_sig_pkg.sv
package rom_sig_pkg;

  localparam int unsigned SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

  // Advance the signature by one whole word, most significant bit first.
  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] cur,
                                                input logic [SIG_W-1:0] word);
    logic [SIG_W-1:0] acc;
    logic             fb;
    acc = cur;
    for (int b = SIG_W - 1; b >= 0; b--) begin
      fb  = acc[SIG_W-1] ^ word[b];
      acc = {acc[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
    end
    return acc;
  endfunction

endpackage

// File: rtl/rom_sig_addr_gen.sv
module rom_sig_addr_gen #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              issue_vld_o,
  output logic              issue_last_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic              run_q;
  logic [ADDR_W-1:0] cnt_q;

  assign addr_o       = cnt_q;
  assign issue_vld_o  = run_q;
  assign issue_last_o = run_q && (cnt_q == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (issue_last_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rom_sig_acc.sv
module rom_sig_acc
  import rom_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             fold_i,
  input  logic [SIG_W-1:0] word_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q;

  assign sig_o = sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sig_q <= SIG_SEED;
    else if (launch_i) sig_q <= SIG_SEED;
    else if (fold_i)   sig_q <= sig_step(sig_q, word_i);
  end
endmodule

// File: rtl/rom_sig_cmp.sv
module rom_sig_cmp
  import rom_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             judge_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] ref_i,
  output logic             done_o,
  output logic             pass_o
);
  logic done_q, pass_q;

  assign done_o = done_q;
  assign pass_o = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= judge_i;
      if (launch_i)     pass_q <= 1'b0;
      else if (judge_i) pass_q <= (sig_i == ref_i);
    end
  end
endmodule

// File: rtl/rom_sig_chk.sv
module rom_sig_chk
  import rom_sig_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = SIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              done_o,
  output logic              pass_o
);
  // Named internal events, also used by the bound checker.
  logic             issue_vld, issue_last;
  logic             rd_vld_q, rd_last_q;
  logic             start_acc;
  logic             fold_en, judge_en;
  logic [SIG_W-1:0] sig_cur;

  assign start_acc = start_i && !issue_vld && !rd_vld_q;
  assign fold_en   = rd_vld_q && !rd_last_q;
  assign judge_en  = rd_vld_q && rd_last_q;

  rom_sig_addr_gen #(.ADDR_W(ADDR_W)) addr_gen_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (start_acc),
    .addr_o      (rom_addr_o),
    .issue_vld_o (issue_vld),
    .issue_last_o(issue_last)
  );

  // Read data returns one cycle after the address: align the control with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_last_q <= 1'b0;
    end else begin
      rd_vld_q  <= issue_vld;
      rd_last_q <= issue_last;
    end
  end

  rom_sig_acc acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(start_acc),
    .fold_i  (fold_en),
    .word_i  (rom_data_i[SIG_W-1:0]),
    .sig_o   (sig_cur)
  );

  rom_sig_cmp cmp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(start_acc),
    .judge_i (judge_en),
    .sig_i   (sig_cur),
    .ref_i   (rom_data_i[SIG_W-1:0]),
    .done_o  (done_o),
    .pass_o  (pass_o)
  );
endmodule

// File: rtl/rom_sig_chk_sva.sv
module rom_sig_chk_sva #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              issue_vld,
  input logic              issue_last,
  input logic              rd_vld_q,
  input logic              rd_last_q,
  input logic              start_acc
);
  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (issue_vld && rom_addr_o == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !issue_last) |=> (rom_addr_o == ADDR_W'($past(rom_addr_o) + 1'b1)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  pass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> done_o);

  // R6
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !(rd_vld_q && rd_last_q)) |=> $stable(pass_o));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !issue_last && start_i) |=> issue_vld);
endmodule

bind rom_sig_chk rom_sig_chk_sva #(.ADDR_W(ADDR_W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rom_addr_o(rom_addr_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .issue_vld (issue_vld),
  .issue_last(issue_last),
  .rd_vld_q  (rd_vld_q),
  .rd_last_q (rd_last_q),
  .start_acc (start_acc)
);

// File: tb/rom_sig_chk_tb.sv
module rom_sig_chk_tb_top;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int W     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] rom_addr_o;
  logic [W-1:0]  rom_data_i;
  logic          done_o, pass_o;

  logic [W-1:0] mem [DEPTH];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rom_sig_chk #(.ADDR_W(AW), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_data_i), .done_o(done_o), .pass_o(pass_o)
  );

  always_ff @(posedge clk) rom_data_i <= mem[rom_addr_o];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent signature model: XOR the word in, then shift it through.
  function automatic logic [W-1:0] model_sig(input logic [W-1:0] seed);
    logic [W-1:0] s;
    s = seed;
    for (int a = 0; a < DEPTH - 1; a++) begin
      s ^= mem[a];
      for (int k = 0; k < W; k++)
        s = s[W-1] ? ((s << 1) ^ 16'h1021) : (s << 1);
    end
    return s;
  endfunction

  task automatic sign_image();
    mem[DEPTH-1] = model_sig(16'hFFFF);
  endtask

  task automatic fill(input int kind);
    logic [W-1:0] x;
    x = 16'hACE1;
    for (int a = 0; a < DEPTH - 1; a++) begin
      case (kind)
        0: mem[a] = '0;
        1: mem[a] = W'(a);
        2: mem[a] = a[0] ? 16'h5555 : 16'hAAAA;
        default: begin
          x = x ^ (x << 7); x = x ^ (x >> 9); x = x ^ (x << 8);
          mem[a] = x;
        end
      endcase
    end
    sign_image();
  endtask

  // One run: checks address order (R2), latency and width (R3), clear (R6), result.
  task automatic run(input logic exp_pass, input string req, input bit poke);
    int j;
    int addr_err;
    addr_err = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R6 pass cleared at start", pass_o, 0);
    j = 0;
    while (!done_o && j < DEPTH + 20) begin
      if (j < DEPTH && rom_addr_o !== AW'(j)) addr_err++;
      start_i = (poke && j == 10);   // R7 mid-run start
      @(negedge clk);
      j++;
    end
    start_i = 1'b0;
    check(poke ? "R7 address order with extra start" : "R2 address order", addr_err, 0);
    check(poke ? "R7 done latency with extra start" : "R3 done latency", j, DEPTH + 1);
    check(req, pass_o, exp_pass);
    @(negedge clk);
    check("R3 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    check("R1 done at reset", done_o, 0);
    check("R1 pass at reset", pass_o, 0);
    check("R1 addr at reset", rom_addr_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after release", done_o, 0);
    check("R1 addr after release", rom_addr_o, 0);
  endtask

  task automatic t_clean();
    for (int k = 0; k < 4; k++) begin
      fill(k);
      run(1'b1, "R4 R5 clean image passes", 1'b0);
    end
    fill(3);
    mem[DEPTH-1] = model_sig(16'h0000);
    run(1'b0, "R4 image signed with seed 0 fails", 1'b0);
  endtask

  task automatic t_hold();
    fill(2);
    run(1'b1, "R5 pass before hold", 1'b0);
    repeat (6) @(negedge clk);
    check("R6 pass held after run", pass_o, 1);
    run(1'b1, "R7 R5 run with ignored start", 1'b1);
  endtask

  task automatic t_errors();
    fill(3); mem[17] ^= 16'h0100;
    run(1'b0, "R8 single data bit", 1'b0);
    fill(3); mem[DEPTH-1] ^= 16'h0001;
    run(1'b0, "R8 single reference bit", 1'b0);
    fill(1); mem[3] ^= 16'h8000; mem[50] ^= 16'h0002;
    run(1'b0, "R9 double bit", 1'b0);
    fill(0); mem[5] ^= 16'h0010; mem[6] ^= 16'h0400; mem[40] ^= 16'h0001;
    run(1'b0, "R10 triple bit", 1'b0);
    fill(3); mem[20] ^= 16'h000F; mem[21] ^= 16'hFF00;
    run(1'b0, "R11 12-bit burst across words", 1'b0);
  endtask

  task automatic t_stuck();
    logic exp;
    fill(3);
    for (int a = 0; a < DEPTH; a++) mem[a] &= ~16'h0020;
    exp = (model_sig(16'hFFFF) == mem[DEPTH-1]);
    run(exp, "R12 column stuck at 0", 1'b0);
    fill(2);
    for (int a = 0; a < DEPTH; a++) mem[a] |= 16'h0008;
    exp = (model_sig(16'hFFFF) == mem[DEPTH-1]);
    run(exp, "R12 column stuck at 1", 1'b0);
  endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    t_reset();
    t_clean();
    t_hold();
    t_errors();
    t_stuck();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule